// File: doc/BRIEF.md
# E1 CAS Multiframe Alignment Finder

This block sits behind an E1 basic frame aligner. For every frame it takes the timeslot-16 octet, marked by a one-cycle frame strobe. From that stream it finds and keeps channel-associated-signalling multiframe alignment. While it is out of alignment it hunts for the 0000 alignment nibble. One of two search rules is used, chosen by a static mode input:

- The strict rule needs a long run of non-matching frames ahead of the candidate.
- The G.732-style rule needs only one nonzero frame ahead of the candidate.

Once aligned, the block numbers each frame within the 16-frame multiframe and checks the alignment nibble every time frame 0 comes round. It pulses an error output when the nibble is wrong. It falls back to searching after consecutive errors, or at once when basic frame alignment is lost. It also reports a debounced copy of the remote multiframe alarm bit. While unaligned, it flags timeslot-16 AIS.

Bits are numbered in transmission order, with bit 1 as the octet MSB. The alignment nibble, bits 1-4, is therefore `ts16[7:4]`, and the alarm bit, bit 6, is `ts16[2]`. All outputs are registered and change in the cycle after the strobe that causes the change.

Top module: `cas_mf_align`

## Requirements
- R1: After reset the outputs read: `oomf`=1, `mf_num`=0, `pat_err`=0, `rmfa`=0, `ts16_ais`=0.
- R2: With `mode_g732`=0, a frame with `ts16[7:4]`=0000 declares alignment only when it follows at least 15 consecutive frames whose `ts16[7:4]` is nonzero. The frame that declares alignment is frame 0, so `oomf` falls and `mf_num` reads 0.
- R3: With `mode_g732`=1, a frame with `ts16[7:4]`=0000 declares alignment when the frame just before it, since the search restarted, had a nonzero `ts16[7:4]`.
- R4: A 0000 frame that does not qualify empties the history of nonzero frames, so the count starts again from zero.
- R5: While aligned, `mf_num` advances by one per strobe, modulo 16, and holds between strobes. While out of alignment it reads 0.
- R6: While aligned, a frame 0 whose `ts16[7:4]` is not 0000 raises `pat_err` for exactly one cycle.
- R7: Two errored frame-0 nibbles in a row set `oomf`=1 and `mf_num`=0, and restart the search with an empty history. A correct frame 0 between two errors resets the error count.
- R8: `rmfa` takes `ts16[2]` from correctly aligned frame-0 octets. It changes only when two consecutive such octets agree, and the frame that declared alignment counts as the first. It reads 0 while `oomf`=1.
- R9: While `oomf`=1, `ts16_ais` rises after the second consecutive octet equal to 8'hFF and falls at the next octet that is not 8'hFF. It reads 0 while aligned.
- R10: `fa_lost`=1 forces `oomf`=1 and `mf_num`=0 in the next cycle and clears all history. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fa_lost | input | 1 | Basic frame alignment lost (level) |
| mode_g732 | input | 1 | 0: strict 15-frame search, 1: nonzero-predecessor search |
| frame_stb | input | 1 | One-cycle strobe qualifying `ts16` |
| ts16 | input | 8 | Timeslot-16 octet, bit 1 in the MSB |
| oomf | output | 1 | Out of multiframe alignment |
| mf_num | output | 4 | Frame number within the multiframe |
| pat_err | output | 1 | One-cycle frame-0 alignment nibble error |
| rmfa | output | 1 | Debounced remote multiframe alarm |
| ts16_ais | output | 1 | Timeslot-16 AIS detected while unaligned |

## Verification
The strict search is tested twice with too-short runs of nonzero nibbles, 10 and then 14, before each 0000 frame. A run of 15 is then tested, which separates a threshold of 15 from 14 or 16 and shows that a failed candidate resets the history. The G.732-style rule is tested with a 0000 frame straight after a loss, with two 0000 frames in a row, and with a nonzero-then-zero pair; these show whether the predecessor must be nonzero and whether the history is cleared on loss. Frame-0 error patterns come as an isolated error followed by a good frame and as a back-to-back pair, which separates the loss rule from a plain error tally. The alarm bit flips for single multiframes and for pairs, showing the debounce. AIS runs of one and two 8'hFF octets separate the two-frame rule from a single-frame one.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;

  // Fields of interest in one timeslot-16 octet (bit 1 is the MSB).
  typedef struct packed {
    logic nib_zero;   // bits 1-4 hold the alignment pattern 0000
    logic all_ones;   // whole octet is 8'hFF
    logic alarm_bit;  // bit 6, remote multiframe alarm
  } ts16_info_t;

  function automatic ts16_info_t decode_ts16(input logic [7:0] oct);
    ts16_info_t r;
    r.nib_zero  = (oct[7:4] == 4'h0);
    r.all_ones  = (oct == 8'hFF);
    r.alarm_bit = oct[2];
    return r;
  endfunction

endpackage

// File: rtl/cas_mf_search.sv
module cas_mf_search #(
  parameter int PRE_LEN = 15,
  parameter int RUN_W   = $clog2(PRE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic nib_zero,
  input  logic mode_g732,
  output logic found
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PRE_LEN);

  logic [RUN_W-1:0] run_q, run_d;
  logic             qualified;
  logic             run_en;

  always_comb begin
    qualified = mode_g732 ? (run_q != '0) : (run_q >= RUN_MAX);
    found     = stb & ~clr & nib_zero & qualified;
    run_en    = clr | stb;
    run_d     = run_q;
    if (clr)
      run_d = '0;
    else if (stb) begin
      if (nib_zero)
        run_d = '0;
      else if (run_q != RUN_MAX)
        run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (run_en)
      run_q <= run_d;
  end

endmodule

// File: rtl/cas_rmfa_debounce.sv
module cas_rmfa_debounce (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic sample,
  input  logic bit_in,
  output logic rmfa_q
);

  logic prev_q, prev_d, rmfa_d, upd_en;

  always_comb begin
    upd_en = clr | load | sample;
    prev_d = prev_q;
    rmfa_d = rmfa_q;
    if (clr) begin
      prev_d = 1'b0;
      rmfa_d = 1'b0;
    end else if (load) begin
      prev_d = bit_in;
      rmfa_d = 1'b0;
    end else if (sample) begin
      prev_d = bit_in;
      if (bit_in == prev_q)
        rmfa_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rmfa_q <= 1'b0;
    end else if (upd_en) begin
      prev_q <= prev_d;
      rmfa_q <= rmfa_d;
    end
  end

endmodule

// File: rtl/cas_ts16_ais.sv
module cas_ts16_ais #(
  parameter int AIS_FRAMES = 2,
  parameter int CNT_W      = $clog2(AIS_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic all_ones,
  output logic ais
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(AIS_FRAMES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | stb;
    cnt_d  = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (stb) begin
      if (!all_ones)
        cnt_d = '0;
      else if (cnt_q != CNT_MAX)
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign ais = (cnt_q == CNT_MAX);

endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
  parameter int PRE_LEN    = 15,
  parameter int LOSS_ERRS  = 2,
  parameter int MF_LEN     = 16,
  parameter int AIS_FRAMES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fa_lost,
  input  logic                      mode_g732,
  input  logic                      frame_stb,
  input  logic [7:0]                ts16,
  output logic                      oomf,
  output logic [$clog2(MF_LEN)-1:0] mf_num,
  output logic                      pat_err,
  output logic                      rmfa,
  output logic                      ts16_ais
);
  import cas_mf_pkg::*;

  localparam int MF_W  = $clog2(MF_LEN);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);
  localparam logic [MF_W-1:0]  MF_LAST  = MF_W'(MF_LEN - 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_ERRS - 1);

  ts16_info_t       info;
  logic             oomf_q, oomf_d;
  logic [MF_W-1:0]  mf_q, mf_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             perr_q, perr_d;
  logic             state_en;
  logic             found, alarm_sample;
  logic             srch_clr, deb_clr, ais_clr;
  logic             deb_q;

  assign info     = decode_ts16(ts16);
  assign srch_clr = fa_lost | ~oomf_q;
  assign deb_clr  = fa_lost | (oomf_q & ~found);
  assign ais_clr  = fa_lost | ~oomf_q;

  cas_mf_search #(.PRE_LEN(PRE_LEN)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (srch_clr),
    .stb      (frame_stb),
    .nib_zero (info.nib_zero),
    .mode_g732(mode_g732),
    .found    (found)
  );

  cas_rmfa_debounce u_debounce (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (deb_clr),
    .load  (found),
    .sample(alarm_sample),
    .bit_in(info.alarm_bit),
    .rmfa_q(deb_q)
  );

  cas_ts16_ais #(.AIS_FRAMES(AIS_FRAMES)) u_ais (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ais_clr),
    .stb     (frame_stb),
    .all_ones(info.all_ones),
    .ais     (ts16_ais)
  );

  // Multiframe state: search / lock, frame counter, error run.
  always_comb begin
    state_en     = fa_lost | frame_stb;
    oomf_d       = oomf_q;
    mf_d         = mf_q;
    err_d        = err_q;
    perr_d       = 1'b0;
    alarm_sample = 1'b0;
    if (fa_lost) begin
      oomf_d = 1'b1;
      mf_d   = '0;
      err_d  = '0;
    end else if (frame_stb) begin
      if (oomf_q) begin
        if (found) begin
          oomf_d = 1'b0;
          mf_d   = '0;
          err_d  = '0;
        end
      end else begin
        mf_d = (mf_q == MF_LAST) ? '0 : mf_q + 1'b1;
        if (mf_q == MF_LAST) begin
          if (info.nib_zero) begin
            err_d        = '0;
            alarm_sample = 1'b1;
          end else begin
            perr_d = 1'b1;
            if (err_q == ERR_LAST) begin
              oomf_d = 1'b1;
              mf_d   = '0;
              err_d  = '0;
            end else begin
              err_d = err_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oomf_q <= 1'b1;
      mf_q   <= '0;
      err_q  <= '0;
    end else if (state_en) begin
      oomf_q <= oomf_d;
      mf_q   <= mf_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      perr_q <= 1'b0;
    else
      perr_q <= perr_d;
  end

  assign oomf    = oomf_q;
  assign mf_num  = mf_q;
  assign pat_err = perr_q;
  assign rmfa    = deb_q & ~oomf_q;

endmodule

// File: rtl/cas_mf_align_chk.sv
module cas_mf_align_chk #(
  parameter int MF_LEN = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fa_lost,
  input logic                      frame_stb,
  input logic [7:0]                ts16,
  input logic                      oomf,
  input logic [$clog2(MF_LEN)-1:0] mf_num,
  input logic                      pat_err,
  input logic                      rmfa,
  input logic                      ts16_ais
);
  localparam int MF_W = $clog2(MF_LEN);
  localparam logic [MF_W-1:0] MF_LAST = MF_W'(MF_LEN - 1);

  // R2
  lock_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oomf) |-> $past(frame_stb) && ($past(ts16[7:4]) == 4'h0));

  // R5
  mf_zero_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oomf |-> (mf_num == '0));

  // R5
  mf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb && !fa_lost |=> $stable(mf_num) && $stable(oomf));

  // R5
  mf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && !fa_lost && !oomf && (mf_num != MF_LAST)
      |=> (mf_num == MF_W'($past(mf_num) + 1'b1)));

  // R6
  perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_err |-> $past(frame_stb) && !$past(oomf) && ($past(mf_num) == MF_LAST));

  // R6
  perr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_err |=> !pat_err);

  // R8
  rmfa_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oomf |-> !rmfa);

  // R9
  ais_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oomf |-> !ts16_ais);

  // R10
  fa_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fa_lost |=> oomf && !pat_err && (mf_num == '0));

endmodule

bind cas_mf_align cas_mf_align_chk #(.MF_LEN(MF_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fa_lost  (fa_lost),
  .frame_stb(frame_stb),
  .ts16     (ts16),
  .oomf     (oomf),
  .mf_num   (mf_num),
  .pat_err  (pat_err),
  .rmfa     (rmfa),
  .ts16_ais (ts16_ais)
);

// File: tb/test_cas_mf_align.sv
module test_cas_mf_align;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fa_lost = 1'b0;
  logic       mode_g732 = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] ts16 = 8'h00;
  logic       oomf, pat_err, rmfa, ts16_ais;
  logic [3:0] mf_num;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state
  int m_oomf, m_mf, m_run, m_errs, m_pe, m_ais_cnt, m_deb, m_prevbit;

  cas_mf_align i_cas_mf_align (
    .clk(clk), .rst_n(rst_n), .fa_lost(fa_lost), .mode_g732(mode_g732),
    .frame_stb(frame_stb), .ts16(ts16), .oomf(oomf), .mf_num(mf_num),
    .pat_err(pat_err), .rmfa(rmfa), .ts16_ais(ts16_ais)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_oomf = 1; m_mf = 0; m_run = 0; m_errs = 0; m_pe = 0;
    m_ais_cnt = 0; m_deb = 0; m_prevbit = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      m_pe = 0;
      if (fa_lost) model_clear();
      else if (frame_stb) begin
        if (m_oomf == 1) begin
          bit hit;
          hit = (ts16[7:4] == 0) && (mode_g732 ? (m_run > 0) : (m_run >= 15));
          m_ais_cnt = (ts16 == 8'hFF) ? ((m_ais_cnt < 2) ? m_ais_cnt + 1 : 2) : 0;
          if (hit) begin
            m_oomf = 0; m_mf = 0; m_run = 0; m_errs = 0;
            m_prevbit = ts16[2]; m_deb = 0; m_ais_cnt = 0;
          end else if (ts16[7:4] == 0) m_run = 0;
          else if (m_run < 15) m_run++;
        end else begin
          m_mf = (m_mf + 1) % 16;
          if (m_mf == 0) begin
            if (ts16[7:4] != 0) begin
              m_pe = 1;
              m_errs++;
              if (m_errs >= 2) begin
                m_oomf = 1; m_mf = 0; m_errs = 0; m_run = 0; m_deb = 0;
              end
            end else begin
              m_errs = 0;
              if (ts16[2] == m_prevbit) m_deb = ts16[2];
              m_prevbit = ts16[2];
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 oomf", oomf, m_oomf);
      check("R5 mf_num", mf_num, m_mf);
      check("R6 pat_err", pat_err, m_pe);
      check("R8 rmfa", rmfa, (m_oomf == 1) ? 0 : m_deb);
      check("R9 ts16_ais", ts16_ais, (m_oomf == 1 && m_ais_cnt == 2) ? 1 : 0);
    end
  end

  task automatic frame(input logic [7:0] v);
    @(negedge clk);
    frame_stb = 1'b1;
    ts16 = v;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic frames(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) frame(v);
  endtask

  task automatic burst(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_stb = 1'b1;
      ts16 = v;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oomf", oomf, 1);
    check("R1 mf_num", mf_num, 0);
    check("R1 pat_err", pat_err, 0);
    check("R1 rmfa", rmfa, 0);
    check("R1 ts16_ais", ts16_ais, 0);

    // Strict search: short runs must not lock (R4), 15 must (R2)
    frames(10, 8'h5A); frame(8'h00);
    check("R4 short run 10", oomf, 1);
    frames(14, 8'h5A); frame(8'h00);
    check("R4 short run 14", oomf, 1);
    frames(15, 8'h5A); frame(8'h04);
    check("R2 lock after 15", oomf, 0);
    check("R2 frame 0", mf_num, 0);

    // Alarm debounce (R8)
    frames(15, 8'h3C); frame(8'h04);
    check("R8 alarm set", rmfa, 1);
    frames(15, 8'h3C); frame(8'h00);
    check("R8 single flip held", rmfa, 1);
    frames(15, 8'h3C); frame(8'h00);
    check("R8 alarm cleared", rmfa, 0);

    // Isolated error, then error pair (R6, R7)
    frames(15, 8'h3C); frame(8'h80);
    check("R6 pulse", pat_err, 1);
    check("R7 single error keeps lock", oomf, 0);
    frames(15, 8'h3C); frame(8'h00);
    frames(15, 8'h3C); frame(8'h80);
    check("R7 after reset count", oomf, 0);
    frames(15, 8'h3C); frame(8'h90);
    check("R7 loss oomf", oomf, 1);
    check("R7 loss mf_num", mf_num, 0);

    // TS16 AIS while unaligned (R9)
    frame(8'hFF);
    check("R9 one frame", ts16_ais, 0);
    frame(8'hFF);
    check("R9 two frames", ts16_ais, 1);
    frame(8'h7F);
    check("R9 cleared", ts16_ais, 0);

    // G.732-style search (R3)
    mode_g732 = 1'b1;
    frame(8'h00);
    check("R3 lock after nonzero", oomf, 0);
    frames(15, 8'h3C); frame(8'h80);
    frames(15, 8'h3C); frame(8'h80);
    check("R7 loss in mode B", oomf, 1);
    frame(8'h00);
    check("R3 empty history", oomf, 1);
    frame(8'h00);
    check("R3 zero predecessor", oomf, 1);
    frame(8'h20); frame(8'h00);
    check("R3 lock", oomf, 0);

    // Loss of basic frame alignment with a strobe (R10)
    frames(5, 8'h3C);
    @(negedge clk);
    fa_lost = 1'b1; frame_stb = 1'b1; ts16 = 8'h00;
    @(negedge clk);
    fa_lost = 1'b0; frame_stb = 1'b0;
    check("R10 oomf", oomf, 1);
    check("R10 mf_num", mf_num, 0);
    frame(8'h00);
    check("R10 history cleared", oomf, 1);

    // Back-to-back strobes in strict mode (R2, R5)
    mode_g732 = 1'b0;
    burst(15, 8'h61);
    burst(1, 8'h00);
    burst(20, 8'h3C);
    @(negedge clk);
    frame_stb = 1'b0;
    @(negedge clk);
    check("R5 mf after burst", mf_num, 4);
    check("R2 burst lock", oomf, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule